// File: doc/BRIEF.md
# Phase-Aligned Display Bus Arbiter

This block decides who drives a shared DRAM display bus: a processor or a DMA engine. A refresh request is also served on this bus. The processor clock runs at exactly twice the frequency of the memory bus clock and is synchronous with it. The block runs on the fast clock and keeps a phase bit that tells which half of the bus-clock period the current edge belongs to. Every memory cycle starts in the first half of a bus-clock period and lasts two bus-clock periods, which is four fast clocks.

The processor is never refused. Its access is paced only by when its acknowledge arrives. A request raised in the wrong phase, or during a DMA or refresh cycle, simply sees a later acknowledge. The DMA engine announces ahead of time that it wants the bus, using an active-low request. At each cycle boundary the block hands the bus to the winner. It captures that requester's address and write flag, multiplexes the row and then the column onto the DRAM address lines, and sequences RAS, CAS and WE. The processor's bus drivers are enabled only while the processor owns the cycle.

Top module: `display_bus_arbiter`

## Requirements
- R1: While reset is held, and until the first grant after reset, `owner` is 00 (none), `ras_n`, `cas_n` and `we_n` are 1, `cpu_ack` and `cpu_drv_en` are 0, `dram_addr` and `dram_bank` are 0, and `bus_phase` is 0 during reset.
- R2: After reset, `bus_phase` toggles on every clock. A memory cycle always begins (slot 0) on a clock where `bus_phase` is 0, and it lasts four clocks (slots 0 to 3).
- R3: The block grants a processor request at the next cycle boundary. `cpu_ack` is high for exactly one clock, in slot 2 of a processor cycle, while `bus_phase` is 0. Start from an idle bus and raise a request just before a boundary edge: `cpu_ack` is seen 3 clocks later. A request raised one clock earlier, in the other phase, is seen 4 clocks later.
- R4: At a cycle boundary the winner is picked in this order: refresh (`ref_req` high), then DMA (`dma_req_n` low), then processor (`cpu_req` high). A waiting processor gets no acknowledge while another owner holds the bus.
- R5: A cycle in progress always runs all four slots. A higher-priority request that arrives mid-cycle is granted only at the next boundary.
- R6: `cpu_drv_en` is high exactly while `owner` is 01 (processor).
- R7: The block captures the address at grant, from `cpu_addr` or `dma_addr` (19 bits). `dram_bank` is bit 18 for the whole cycle. `dram_addr` carries bits 17:9 (row) in slots 0 and 1, and bits 8:0 (column) in slots 2 and 3.
- R8: In a processor or DMA cycle, `ras_n` is low in slots 1 to 3 and `cas_n` is low only in slot 3. `we_n` is low in slots 1 to 3 if the captured write flag (`cpu_we` or `dma_we`) was 1, and stays high otherwise.
- R9: A refresh cycle is CAS-before-RAS. `cas_n` is low in slots 1 to 3, `ras_n` is low in slots 2 and 3, and `we_n` stays high. `dram_addr` and `dram_bank` are 0 in a refresh cycle and when the bus is idle.
- R10: `owner` encodes 00 none, 01 processor, 10 DMA, 11 refresh. A boundary with no request leaves the bus idle (00).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (processor) clock, twice the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor wants a memory cycle; held until acknowledged |
| cpu_we | input | 1 | Processor cycle is a write |
| cpu_addr | input | 19 | Processor word address: bank, row, column |
| dma_req_n | input | 1 | Active-low advance bus request from the DMA engine |
| dma_we | input | 1 | DMA cycle is a write |
| dma_addr | input | 19 | DMA address register value |
| ref_req | input | 1 | Refresh cycle request |
| bus_phase | output | 1 | Half of the bus-clock period the current clock falls in |
| owner | output | 2 | Current cycle owner |
| cpu_ack | output | 1 | Processor transfer acknowledge |
| cpu_drv_en | output | 1 | Enable for the processor's display-bus drivers |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_bank | output | 1 | Bank select for the expansion half |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The hardest case to reach is the one where requests collide at a single boundary edge. A DMA request or a refresh request lands while a processor cycle is still in its middle slots, and a new processor request is already waiting behind it. Whether anything is preempted depends on the exact clock the request rises on. The stimulus therefore times each request from the bench's own phase and slot count. It raises the DMA request one clock after a processor grant, and it raises refresh and DMA together. It also times processor requests to fall on both phases, so that the acknowledge latency shows the stretch.

// File: rtl/dba_pkg.sv
// Shared types and constants for the display bus arbiter.
// Assumes a fixed four-slot memory cycle (two bus-clock periods).
package dba_pkg;
    typedef enum logic [1:0] {
        OWN_NONE = 2'b00,
        OWN_CPU  = 2'b01,
        OWN_DMA  = 2'b10,
        OWN_REF  = 2'b11
    } own_t;

    localparam int SLOTS  = 4;
    localparam int SLOT_W = $clog2(SLOTS);
endpackage

// File: rtl/dba_phase.sv
// Tracks which half of the bus-clock period the current fast-clock edge
// falls in. Assumes the bus clock is the fast clock divided by two and
// that reset release marks the start of a bus-clock period.
module dba_phase (
    input  logic clk,
    input  logic rst_n,
    output logic phase
);
    // Toggle once per fast clock; first half after reset is 0.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    AST_PHASE_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (phase != $past(phase))); // R2
endmodule

// File: rtl/dba_grant.sv
// Cycle-boundary arbiter. It picks refresh, then DMA, then processor,
// counts the four slots of the running cycle, and captures the winner's
// address and write flag. Assumes requesters hold their request until
// they are served.
module dba_grant
    import dba_pkg::*;
#(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              dma_req_n,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              ref_req,
    output own_t              owner,
    output logic [SLOT_W-1:0] slot,
    output logic [ADDR_W-1:0] cyc_addr,
    output logic              cyc_we
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic boundary;
    own_t pick;

    // A boundary is the second half of a bus period, with the bus idle or the cycle in its last slot.
    always_comb begin
        boundary = phase && ((owner == OWN_NONE) || (slot == LAST_SLOT));
    end

    // Fixed priority: refresh, then DMA, then processor.
    always_comb begin
        if (ref_req)         pick = OWN_REF;
        else if (!dma_req_n) pick = OWN_DMA;
        else if (cpu_req)    pick = OWN_CPU;
        else                 pick = OWN_NONE;
    end

    // Grant at a boundary, otherwise advance the slot of the running cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner    <= OWN_NONE;
            slot     <= '0;
            cyc_addr <= '0;
            cyc_we   <= 1'b0;
        end else if (boundary) begin
            owner <= pick;
            slot  <= '0;
            unique case (pick)
                OWN_CPU: begin cyc_addr <= cpu_addr; cyc_we <= cpu_we; end
                OWN_DMA: begin cyc_addr <= dma_addr; cyc_we <= dma_we; end
                default: begin cyc_addr <= '0;       cyc_we <= 1'b0;   end
            endcase
        end else if (owner != OWN_NONE) begin
            slot <= slot + 1'b1;
        end
    end

    AST_START_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != OWN_NONE && slot == '0) |-> !phase); // R2
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (owner != OWN_NONE && slot != LAST_SLOT) |=> (owner == $past(owner))); // R5
    AST_DMA_BEFORE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !dma_req_n && !ref_req) |=> (owner == OWN_DMA)); // R4
    AST_REF_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && ref_req) |=> (owner == OWN_REF)); // R4
endmodule

// File: rtl/dba_dram_seq.sv
// Decodes owner and slot into DRAM strobes, the row/column address mux,
// the processor acknowledge and the processor driver enable. It is purely
// combinational on registered state, so outputs change only after a clock edge.
module dba_dram_seq
    import dba_pkg::*;
#(
    parameter int LINE_W = 9,
    parameter int BANK_W = 1,
    localparam int ADDR_W = BANK_W + 2 * LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              phase,
    input  own_t              owner,
    input  logic [SLOT_W-1:0] slot,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              cyc_we,
    output logic [LINE_W-1:0] dram_addr,
    output logic [BANK_W-1:0] dram_bank,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              cpu_ack,
    output logic              cpu_drv_en
);
    localparam logic [SLOT_W-1:0] ACK_SLOT = SLOT_W'(2);
    localparam logic [SLOT_W-1:0] CAS_SLOT = SLOT_W'(SLOTS - 1);

    logic [LINE_W-1:0] row_part;
    logic [LINE_W-1:0] col_part;

    // Split the captured address into row, column and bank fields.
    always_comb begin
        col_part = cyc_addr[LINE_W-1:0];
        row_part = cyc_addr[2*LINE_W-1:LINE_W];
    end

    // Per-slot strobe, mux and handshake decode for each owner type.
    always_comb begin
        dram_addr  = '0;
        dram_bank  = '0;
        ras_n      = 1'b1;
        cas_n      = 1'b1;
        we_n       = 1'b1;
        cpu_ack    = 1'b0;
        cpu_drv_en = 1'b0;
        unique case (owner)
            OWN_CPU, OWN_DMA: begin
                dram_bank = cyc_addr[ADDR_W-1 -: BANK_W];
                dram_addr = (slot < ACK_SLOT) ? row_part : col_part;
                ras_n     = (slot == '0);
                cas_n     = (slot != CAS_SLOT);
                we_n      = !(cyc_we && (slot != '0));
                if (owner == OWN_CPU) begin
                    cpu_drv_en = 1'b1;
                    cpu_ack    = (slot == ACK_SLOT);
                end
            end
            OWN_REF: begin
                cas_n = (slot == '0);
                ras_n = (slot < ACK_SLOT);
            end
            default: ;
        endcase
    end

    AST_ACK_IN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> !phase); // R3
    AST_ACK_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack); // R3
    AST_ACK_NEEDS_DRV: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> cpu_drv_en); // R6
    AST_CAS_AFTER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && owner != OWN_REF) |-> !ras_n); // R8
    AST_REF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_REF) |-> we_n); // R9
endmodule

// File: rtl/display_bus_arbiter.sv
// Top level: processor/DMA display-bus arbiter with bus-clock phase
// alignment, acknowledge stretching, row/column multiplexing and DRAM
// strobe sequencing. Assumes the processor clock is twice the bus clock.
module display_bus_arbiter
    import dba_pkg::*;
#(
    parameter int LINE_W = 9,
    parameter int BANK_W = 1,
    localparam int ADDR_W = BANK_W + 2 * LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              dma_req_n,
    input  logic              dma_we,
    input  logic [ADDR_W-1:0] dma_addr,
    input  logic              ref_req,
    output logic              bus_phase,
    output logic [1:0]        owner,
    output logic              cpu_ack,
    output logic              cpu_drv_en,
    output logic [LINE_W-1:0] dram_addr,
    output logic [BANK_W-1:0] dram_bank,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n
);
    own_t              cur_owner;
    logic [SLOT_W-1:0] cur_slot;
    logic [ADDR_W-1:0] cyc_addr;
    logic              cyc_we;

    dba_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (bus_phase)
    );

    dba_grant #(.ADDR_W(ADDR_W)) u_grant (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase     (bus_phase),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_addr  (cpu_addr),
        .dma_req_n (dma_req_n),
        .dma_we    (dma_we),
        .dma_addr  (dma_addr),
        .ref_req   (ref_req),
        .owner     (cur_owner),
        .slot      (cur_slot),
        .cyc_addr  (cyc_addr),
        .cyc_we    (cyc_we)
    );

    dba_dram_seq #(.LINE_W(LINE_W), .BANK_W(BANK_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase      (bus_phase),
        .owner      (cur_owner),
        .slot       (cur_slot),
        .cyc_addr   (cyc_addr),
        .cyc_we     (cyc_we),
        .dram_addr  (dram_addr),
        .dram_bank  (dram_bank),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .we_n       (we_n),
        .cpu_ack    (cpu_ack),
        .cpu_drv_en (cpu_drv_en)
    );

    // Export the owner encoding as a plain vector.
    always_comb owner = cur_owner;

    AST_DRV_MATCHES_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_drv_en == (owner == 2'b01)); // R6
endmodule

// File: tb/display_bus_arbiter_test.sv
module display_bus_arbiter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic        cpu_we = 1'b0;
    logic [18:0] cpu_addr = '0;
    logic        dma_req_n = 1'b1;
    logic        dma_we = 1'b0;
    logic [18:0] dma_addr = '0;
    logic        ref_req = 1'b0;
    logic        bus_phase;
    logic [1:0]  owner;
    logic        cpu_ack, cpu_drv_en;
    logic [8:0]  dram_addr;
    logic [0:0]  dram_bank;
    logic        ras_n, cas_n, we_n;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench reference model state
    int m_ph = 0, m_own = 0, m_pos = 0, m_addr = 0, m_we = 0;
    int dma_want = 0, ref_want = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    display_bus_arbiter uut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .dma_req_n(dma_req_n), .dma_we(dma_we),
        .dma_addr(dma_addr), .ref_req(ref_req), .bus_phase(bus_phase),
        .owner(owner), .cpu_ack(cpu_ack), .cpu_drv_en(cpu_drv_en),
        .dram_addr(dram_addr), .dram_bank(dram_bank), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n)
    );

    // Behavioural model: elapsed clocks since grant, and who holds the bus.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_own = 0; m_pos = 0; m_addr = 0; m_we = 0;
        end else begin
            bit at_edge;
            at_edge = (m_ph == 1) && (m_own == 0 || m_pos == 3);
            m_ph = 1 - m_ph;
            if (at_edge) begin
                m_pos = 0;
                if (ref_req) begin m_own = 3; m_addr = 0; m_we = 0; end
                else if (!dma_req_n) begin m_own = 2; m_addr = int'(dma_addr); m_we = int'(dma_we); end
                else if (cpu_req) begin m_own = 1; m_addr = int'(cpu_addr); m_we = int'(cpu_we); end
                else begin m_own = 0; m_addr = 0; m_we = 0; end
            end else if (m_own != 0) begin
                m_pos = m_pos + 1;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output with the model at the falling edge, then run requester agents.
    task automatic tick();
        int e_ras, e_cas, e_we, e_addr, e_bank;
        @(negedge clk);
        e_ras = 1; e_cas = 1; e_we = 1; e_addr = 0; e_bank = 0;
        if (m_own == 1 || m_own == 2) begin
            e_ras = (m_pos == 0) ? 1 : 0;
            e_cas = (m_pos == 3) ? 0 : 1;
            e_we  = (m_we != 0 && m_pos >= 1) ? 0 : 1;
            e_addr = (m_pos < 2) ? ((m_addr / 512) % 512) : (m_addr % 512);
            e_bank = (m_addr / 262144) % 2;
        end else if (m_own == 3) begin
            e_cas = (m_pos >= 1) ? 0 : 1;
            e_ras = (m_pos >= 2) ? 0 : 1;
        end
        chk("R2 bus_phase", int'(bus_phase), m_ph);
        chk("R10 owner", int'(owner), m_own);
        chk("R3 cpu_ack", int'(cpu_ack), (m_own == 1 && m_pos == 2) ? 1 : 0);
        chk("R6 cpu_drv_en", int'(cpu_drv_en), (m_own == 1) ? 1 : 0);
        chk("R8 ras_n", int'(ras_n), e_ras);
        chk("R8 cas_n", int'(cas_n), e_cas);
        chk("R8 we_n", int'(we_n), e_we);
        chk("R7 dram_addr", int'(dram_addr), e_addr);
        chk("R7 dram_bank", int'(dram_bank), e_bank);
        if (cpu_req && cpu_ack) cpu_req = 1'b0;
        if (m_own == 2 && m_pos == 0 && dma_want > 0) begin
            dma_want--; if (dma_want == 0) dma_req_n = 1'b1;
        end
        if (m_own == 3 && m_pos == 0 && ref_want > 0) begin
            ref_want--; if (ref_want == 0) ref_req = 1'b0;
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Processor access from idle; checks acknowledge latency against phase (R3).
    task automatic cpu_access(logic [18:0] a, logic w);
        int lat, want;
        want = (m_ph == 1) ? 3 : 4;
        cpu_addr = a; cpu_we = w; cpu_req = 1'b1;
        lat = 0;
        while (cpu_req && lat < 20) begin tick(); lat++; end
        chk("R3 ack latency", lat, want);
        idle(2);
    endtask

    initial begin
        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R1 owner", int'(owner), 0);
            chk("R1 ras_n", int'(ras_n), 1);
            chk("R1 cas_n", int'(cas_n), 1);
            chk("R1 we_n", int'(we_n), 1);
            chk("R1 cpu_ack", int'(cpu_ack), 0);
            chk("R1 cpu_drv_en", int'(cpu_drv_en), 0);
            chk("R1 bus_phase", int'(bus_phase), 0);
        end
        rst_n = 1'b1;
        idle(4);

        // R3/R7/R8: reads and writes in both phases
        while (m_ph != 1) tick();
        cpu_access(19'h5_A5C3, 1'b0);
        while (m_ph != 0) tick();
        cpu_access(19'h2_3E71, 1'b1);
        cpu_access(19'h7_FFFF, 1'b1);
        cpu_access(19'h0_0001, 1'b0);

        // R5: DMA request arrives one clock into a processor cycle
        while (m_ph != 1) tick();
        cpu_addr = 19'h1_2345; cpu_we = 1'b0; cpu_req = 1'b1;
        tick();
        dma_addr = 19'h6_789A; dma_we = 1'b1; dma_want = 1; dma_req_n = 1'b0;
        tick();
        chk("R5 cpu cycle not preempted", int'(owner), 1);
        idle(12);

        // R4: refresh and DMA together, processor waiting behind both
        while (m_ph != 0) tick();
        ref_want = 1; ref_req = 1'b1;
        dma_addr = 19'h4_0F0F; dma_we = 1'b0; dma_want = 2; dma_req_n = 1'b0;
        cpu_addr = 19'h3_3333; cpu_we = 1'b1; cpu_req = 1'b1;
        tick(); tick();
        chk("R4 refresh wins", int'(owner), 3);
        for (int i = 0; i < 8; i++) begin
            tick();
            if (cpu_ack) begin checks++; fails++; $display("FAIL R4 cpu_ack actual=1 expected=0"); end
        end
        idle(20);
        chk("R4 cpu served after others", int'(cpu_req), 0);

        // R9/R10: lone refresh, then idle boundary
        ref_want = 1; ref_req = 1'b1;
        idle(12);
        chk("R10 idle owner", int'(owner), 0);
        chk("R9 idle addr", int'(dram_addr), 0);

        // Back-to-back processor requests
        cpu_addr = 19'h5_5555; cpu_we = 1'b1; cpu_req = 1'b1;
        while (cpu_req) tick();
        cpu_addr = 19'h2_AAAA; cpu_we = 1'b0; cpu_req = 1'b1;
        idle(10);
        chk("R3 second request served", int'(cpu_req), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end
endmodule